// File: doc/BRIEF.md
# Splittable Look-Up Table with Serial Configuration

This block is the logic core of a small programmable logic element. It holds a truth table of 2^K bits and one mode bit, all written through a serial scan chain that runs on its own configuration clock. When the mode bit is 1 the block is one K-input function of its logic inputs. When the mode bit is 0 the highest select input is pinned high and the block acts as two independent (K-1)-input functions. The lower and upper halves of the table each drive their own output, tapped one level below the root of the selection tree.

The chain shifts one bit per enabled configuration clock edge. The table bits go in least significant first and the mode bit goes in last. The far end of the chain is a serial output, so several elements can be chained to form a longer configuration path. A configuration reset clears every stored bit. After reset the block therefore sits in the two-function mode with an all-zero table.

Top module: `frac_lut`

## Requirements
- R1: Let N = 2^K + 1. The chain advances only on rising edges of `cfg_clk` with `cfg_en` high. After the k-th such edge, `cfg_sout` equals the `cfg_sin` value taken at the (k-N+1)-th such edge. Before N edges have occurred since reset, `cfg_sout` is 0.
- R2: On an edge with `cfg_en` low, `cfg_sin` is ignored and nothing changes: `cfg_sout` and all three function outputs keep their values.
- R3: Consider N enabled shifts in a row. The first N-1 bits shifted in become truth-table entries T[0] to T[2^K-1], in that order, and the last bit becomes the mode bit.
- R4: With `cfg_rst_n` low, every chain bit is cleared at once, without waiting for a clock edge. The mode bit is then 0, `cfg_sout` is 0, and every function output is 0 for every input.
- R5: With mode bit 1, `lut_out` = T[`lut_in`], where `lut_in[0]` is the least significant index bit.
- R6: With mode bit 0, `lut_in[K-1]` has no effect and is treated as 1, so `lut_out` = T[2^(K-1) + `lut_in[K-2:0]`].
- R7: In both modes, `lut_lo` = T[`lut_in[K-2:0]`], which is independent of `lut_in[K-1]`.
- R8: In both modes, `lut_hi` = T[2^(K-1) + `lut_in[K-2:0]`], which is independent of `lut_in[K-1]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| cfg_clk | input | 1 | Configuration shift clock |
| cfg_rst_n | input | 1 | Asynchronous active-low configuration reset |
| cfg_en | input | 1 | Shift enable for the chain |
| cfg_sin | input | 1 | Serial configuration data in |
| cfg_sout | output | 1 | Serial configuration data out (last chain stage) |
| lut_in | input | K | Logic select inputs, bit 0 least significant |
| lut_out | output | 1 | Full-width function output |
| lut_lo | output | 1 | Lower-half (K-1)-input function output |
| lut_hi | output | 1 | Upper-half (K-1)-input function output |

## Verification
The assertions sample the combinational function outputs on `cfg_clk` edges. They therefore assume that `lut_in` is stable around those edges and that `cfg_rst_n` is released away from an edge. The bench changes `lut_in`, `cfg_sin` and `cfg_en` only at falling edges or between clocked phases, and it releases reset at a falling edge. The reset check relies on `cfg_rst_n` starting low at time zero, which the stimulus guarantees.

// File: rtl/frac_lut_pkg.sv
package frac_lut_pkg;

    // Number of truth-table entries for a K-input function
    function automatic int unsigned tbl_size(input int unsigned k);
        return 32'd1 << k;
    endfunction

    // Total chain length: table plus the mode bit
    function automatic int unsigned chain_len(input int unsigned k);
        return tbl_size(k) + 32'd1;
    endfunction

endpackage

// File: rtl/frac_lut_cfg_chain.sv
module frac_lut_cfg_chain
    import frac_lut_pkg::*;
#(
    parameter int unsigned K = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    en,
    input  logic                    sin,
    output logic                    sout,
    output logic [tbl_size(K)-1:0]  table_bits,
    output logic                    mode
);
    localparam int unsigned TBL = tbl_size(K);
    localparam int unsigned N   = chain_len(K);

    typedef struct packed {
        logic [N-1:0] sr;
    } chain_t;

    chain_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (en) begin
            st_d.sr = {st_q.sr[N-2:0], sin};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // Stage 0 holds the last bit shifted (mode); the far end holds T[0]
    assign sout = st_q.sr[N-1];
    assign mode = st_q.sr[0];

    for (genvar i = 0; i < TBL; i++) begin : g_map
        assign table_bits[i] = st_q.sr[N-1-i];
    end

    AST_CHAIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> ($stable(sout) && $stable(mode) && $stable(table_bits))); // R2

    AST_CHAIN_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        en |=> (sout == $past(table_bits[1]))); // R3

    AST_RST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (sout == 1'b0 && mode == 1'b0 && table_bits == '0)); // R4

endmodule

// File: rtl/frac_lut_top_gate.sv
module frac_lut_top_gate (
    input  logic pin,
    input  logic mode,
    output logic sel
);
    // Mode 0 pins the top select high; mode 1 lets the pin through
    logic force_hi;

    assign force_hi = ~mode;
    assign sel      = pin | force_hi;

endmodule

// File: rtl/frac_lut_mux_tree.sv
module frac_lut_mux_tree
    import frac_lut_pkg::*;
#(
    parameter int unsigned K = 4
) (
    input  logic [tbl_size(K)-1:0] table_bits,
    input  logic [K-1:0]           sel,
    output logic                   root,
    output logic                   tap_lo,
    output logic                   tap_hi
);
    localparam int unsigned TBL = tbl_size(K);

    // Heap-indexed internal nodes: node n has children 2n and 2n+1.
    // Depth d uses select bit K-1-d; leaves are the table entries.
    logic [TBL-1:1] node;

    for (genvar d = 0; d < K; d++) begin : g_depth
        for (genvar j = 0; j < (1 << d); j++) begin : g_node
            localparam int unsigned IDX = (1 << d) + j;
            if (d == K - 1) begin : g_leaf
                assign node[IDX] = sel[K-1-d] ? table_bits[2*j+1]
                                              : table_bits[2*j];
            end else begin : g_inner
                assign node[IDX] = sel[K-1-d] ? node[2*IDX+1]
                                              : node[2*IDX];
            end
        end
    end

    assign root   = node[1];
    assign tap_lo = node[2];
    assign tap_hi = node[3];

endmodule

// File: rtl/frac_lut.sv
module frac_lut
    import frac_lut_pkg::*;
#(
    parameter int unsigned K = 4
) (
    input  logic         cfg_clk,
    input  logic         cfg_rst_n,
    input  logic         cfg_en,
    input  logic         cfg_sin,
    output logic         cfg_sout,
    input  logic [K-1:0] lut_in,
    output logic         lut_out,
    output logic         lut_lo,
    output logic         lut_hi
);
    localparam int unsigned TBL = tbl_size(K);

    logic [TBL-1:0] tbl;
    logic           mode_q;
    logic           top_sel;
    logic [K-1:0]   sel_vec;

    frac_lut_cfg_chain #(.K(K)) u_chain (
        .clk        (cfg_clk),
        .rst_n      (cfg_rst_n),
        .en         (cfg_en),
        .sin        (cfg_sin),
        .sout       (cfg_sout),
        .table_bits (tbl),
        .mode       (mode_q)
    );

    frac_lut_top_gate u_gate (
        .pin  (lut_in[K-1]),
        .mode (mode_q),
        .sel  (top_sel)
    );

    assign sel_vec = {top_sel, lut_in[K-2:0]};

    frac_lut_mux_tree #(.K(K)) u_tree (
        .table_bits (tbl),
        .sel        (sel_vec),
        .root       (lut_out),
        .tap_lo     (lut_lo),
        .tap_hi     (lut_hi)
    );

    AST_DUAL_UPPER: assert property (@(posedge cfg_clk) disable iff (!cfg_rst_n)
        !mode_q |-> (lut_out == lut_hi)); // R6

    AST_SINGLE_SPLIT: assert property (@(posedge cfg_clk) disable iff (!cfg_rst_n)
        mode_q |-> (lut_out == (lut_in[K-1] ? lut_hi : lut_lo))); // R5

    AST_TAPS_NO_TOP: assert property (@(posedge cfg_clk) disable iff (!cfg_rst_n)
        ($stable(lut_in[K-2:0]) && $stable(tbl)) |-> ($stable(lut_lo) && $stable(lut_hi))); // R7

endmodule

// File: tb/frac_lut_tb.sv
module frac_lut_tb;
    localparam int K   = 4;
    localparam int TBL = 1 << K;
    localparam int N   = TBL + 1;
    localparam int NVEC = 8;

    // Each entry: {mode bit, truth table}
    localparam logic [TBL:0] VEC [NVEC] = '{
        {1'b1, 16'hA5C3}, {1'b0, 16'hA5C3}, {1'b1, 16'h0001}, {1'b0, 16'h8000},
        {1'b1, 16'hFFFF}, {1'b0, 16'h0000}, {1'b1, 16'h6996}, {1'b0, 16'h00FF}
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         en = 1'b0;
    logic         sin = 1'b0;
    logic [K-1:0] lin = '0;
    wire          sout, yout, ylo, yhi;

    int  checks = 0;
    int  errors = 0;
    int  k_edge = 0;
    bit  hist [4096];
    bit  done = 1'b0;

    always #2 clk = ~clk;

    frac_lut #(.K(K)) u_dut (
        .cfg_clk(clk), .cfg_rst_n(rst_n), .cfg_en(en), .cfg_sin(sin),
        .cfg_sout(sout), .lut_in(lin), .lut_out(yout), .lut_lo(ylo), .lut_hi(yhi)
    );

    task automatic check(input string tag, input logic got, input logic exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %b expected %b", tag, got, exp);
        end
    endtask

    function automatic logic model_out(input logic [TBL-1:0] t, input logic m, input logic [K-1:0] x);
        logic [K-1:0] idx;
        idx = {x[K-1] | ~m, x[K-2:0]};
        return t[idx];
    endfunction

    task automatic shift_bit(input logic b);
        @(negedge clk);
        sin = b;
        en  = 1'b1;
        @(posedge clk);
        k_edge++;
        hist[k_edge] = b;
        #1;
        if (k_edge >= N) check("R1 sout delay", sout, hist[k_edge-N+1]);
        else             check("R1 R4 sout cleared", sout, 1'b0);
    endtask

    task automatic load(input logic [TBL-1:0] t, input logic m);
        for (int i = 0; i < TBL; i++) shift_bit(t[i]);   // R3 order: T[0] first
        shift_bit(m);
        @(negedge clk);
        en = 1'b0;
    endtask

    task automatic sweep(input logic [TBL-1:0] t, input logic m);
        for (int x = 0; x < TBL; x++) begin
            lin = x[K-1:0];
            #1;
            if (m) check("R5 single out", yout, model_out(t, m, lin));
            else   check("R6 dual out",   yout, model_out(t, m, lin));
            check("R7 lo tap", ylo, t[{1'b0, lin[K-2:0]}]);
            check("R8 hi tap", yhi, t[{1'b1, lin[K-2:0]}]);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #(4 * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic [TBL-1:0] t;
        logic           m;
        logic           o0, l0, h0, s0;

        // R4: reset state
        #1;
        for (int x = 0; x < TBL; x++) begin
            lin = x[K-1:0];
            #1;
            check("R4 out zero", yout, 1'b0);
            check("R4 lo zero", ylo, 1'b0);
            check("R4 hi zero", yhi, 1'b0);
        end
        check("R4 sout zero", sout, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;

        // Vector table walk
        for (int v = 0; v < NVEC; v++) begin
            t = VEC[v][TBL-1:0];
            m = VEC[v][TBL];
            load(t, m);
            sweep(t, m);
        end

        // Random tables in both modes
        for (int r = 0; r < 6; r++) begin
            t = TBL'($urandom);
            m = r[0];
            load(t, m);
            sweep(t, m);
        end

        // R2: disabled edges ignore cfg_sin
        t = 16'h3C5A;
        load(t, 1'b1);
        lin = 4'b1011;
        #1;
        o0 = yout; l0 = ylo; h0 = yhi; s0 = sout;
        for (int c = 0; c < 5; c++) begin
            @(negedge clk);
            sin = ~sin;
            @(posedge clk);
            #1;
            check("R2 sout hold", sout, s0);
            check("R2 out hold", yout, o0);
            check("R2 lo hold", ylo, l0);
            check("R2 hi hold", yhi, h0);
        end
        sweep(t, 1'b1);

        // R6 corner: top input toggled in dual mode has no effect
        t = 16'hF00F;
        load(t, 1'b0);
        lin = 4'b0010;
        #1;
        o0 = yout;
        lin = 4'b1010;
        #1;
        check("R6 top ignored", yout, o0);
        check("R6 top forced high", yout, t[10]);

        // R4: asynchronous mid-run reset
        @(negedge clk);
        #1;
        rst_n = 1'b0;
        #0.5;
        check("R4 async sout", sout, 1'b0);
        sweep(16'h0000, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        k_edge = 0;
        // R1/R4: first N-1 shifts after reset bring out zeros, including the cleared mode bit
        load(16'hFFFF, 1'b1);
        sweep(16'hFFFF, 1'b1);

        finish_run();
    end
endmodule